// File: doc/BRIEF.md
# Bus Match Comparator Bank

This block watches every cycle of a processor bus and raises one match flag per comparator when the cycle meets that comparator's settings. The bank has four comparators, A to D. A and C check the full address and the 16-bit data bus, and a mask limits the data check to selected bits. B and D check the address only. They can also require that the access be a byte or a word. Any comparator can be limited to read cycles only or to write cycles only.

Comparator A can also pair with comparator B to watch an address window instead of a single address. A's address is the lower bound and B's address is the upper bound. A reports whether the address falls inside the window or outside it, and B stays silent while the pair is in use.

Software loads the settings through a simple write port. The match flags are registered and feed a downstream sequencer. Each flag describes the bus cycle one clock earlier.

Top module: `bus_watch_bank`

## Requirements
- R1: Each comparator holds an address. On a cycle with `busValid` high whose address equals it, and whose other qualifiers pass, the comparator's bit of `match` is 1 on the next clock. Bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D.
- R2: A and C also compare `busData` with their data value. Only the bits set to 1 in their mask take part; mask bits at 0 are ignored.
- R3: B and D ignore `busData` entirely.
- R4: Control bit 2 set to 1 makes the comparator check direction. Bit 1 then selects read cycles (1) or write cycles (0), judged against `busRead`. With bit 2 at 0, both directions match.
- R5: On B and D, control bit 3 set to 1 makes the comparator check access size. Bit 4 then selects word (1) or byte (0), judged against `busWord`. On A and C these two bits have no effect.
- R6: Control bit 0 enables the comparator. A comparator with bit 0 at 0 never sets its match bit.
- R7: A's control bits 6:5 equal to 01 select inside mode. In this mode `match[0]` is 1 when A's address ≤ bus address ≤ B's address, subject to A's enable and direction bits. Data is not compared.
- R8: A's control bits 6:5 equal to 10 select outside mode. In this mode `match[0]` is 1 when the bus address is below A's address or above B's address, subject to A's enable and direction bits.
- R9: While inside or outside mode is active, `match[1]` stays 0. A's bits 6:5 equal to 00 or 11 give independent single-address compares.
- R10: A cycle with `busValid` low gives `match` equal to 0 on the next clock.
- R11: After reset every comparator is disabled, its registers are zero and `match` is 0.
- R12: A write with `cfgWrEn` high selects a comparator with `cfgAddr[3:2]` and a register with `cfgAddr[1:0]`: 0 is control, 1 is address, 2 is data value, 3 is data mask. Data and mask exist only on A and C. A bus cycle in the same clock as a write is judged against the settings held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Settings write strobe |
| cfgAddr | input | 4 | Comparator [3:2] and register [1:0] select |
| cfgWrData | input | ADDR_W | Settings write value; data and mask use the low DATA_W bits |
| busValid | input | 1 | Bus cycle present |
| busAddr | input | ADDR_W | Bus address |
| busData | input | DATA_W | Bus data |
| busRead | input | 1 | 1 for a read cycle, 0 for a write cycle |
| busWord | input | 1 | 1 for a word access, 0 for a byte access |
| match | output | 4 | Registered per-comparator match, bit 0 is A |

## Verification
The same clock can carry both a settings write and a bus cycle that the write's target would judge. The bench provokes this by moving A's address away from the live bus address while that address is on the bus. It expects that cycle to be judged with the old address, and the next identical cycle with the new one. The bench also puts a bus cycle on the bus that satisfies two comparators at once, A with B and C with D, and expects both flags to be set together.

// File: rtl/bus_watch_pkg.sv
package bus_watch_pkg;
  localparam int NUM_CMP = 4;
  localparam int CTRL_W  = 7;

  localparam int BIT_EN       = 0;
  localparam int BIT_RW_SEL   = 1;
  localparam int BIT_RW_CARE  = 2;
  localparam int BIT_SZ_CARE  = 3;
  localparam int BIT_SZ_SEL   = 4;
  localparam int BIT_MODE_LO  = 5;

  localparam logic [1:0] FLD_CTRL = 2'd0;
  localparam logic [1:0] FLD_ADDR = 2'd1;
  localparam logic [1:0] FLD_DATA = 2'd2;
  localparam logic [1:0] FLD_MASK = 2'd3;

  typedef enum logic [1:0] {
    MODE_SIMPLE  = 2'b00,
    MODE_INSIDE  = 2'b01,
    MODE_OUTSIDE = 2'b10,
    MODE_SPARE   = 2'b11
  } rangeMode_e;

  typedef struct packed {
    logic [NUM_CMP-1:0] qual;
    logic               rangeOn;
    logic               rangeInside;
  } cmpStrobe_t;
endpackage

// File: rtl/bus_watch_ctrl.sv
module bus_watch_ctrl
  import bus_watch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgWrEn,
  input  logic [3:0]                      cfgAddr,
  input  logic [ADDR_W-1:0]               cfgWrData,
  input  logic                            busValid,
  input  logic                            busRead,
  input  logic                            busWord,
  output cmpStrobe_t                      strobe,
  output logic [NUM_CMP-1:0][ADDR_W-1:0]  addrCfg,
  output logic [NUM_CMP-1:0][DATA_W-1:0]  dataCfg,
  output logic [NUM_CMP-1:0][DATA_W-1:0]  maskCfg
);
  logic [NUM_CMP-1:0][CTRL_W-1:0] ctrlReg;
  logic [1:0]                     wrCmp;
  logic [1:0]                     wrFld;
  rangeMode_e                     modeA;

  assign wrCmp = cfgAddr[3:2];
  assign wrFld = cfgAddr[1:0];

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic rwOk;
    logic sizeOk;
    logic hitSel;

    assign hitSel = cfgWrEn && (wrCmp == 2'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlReg[i] <= '0;
        addrCfg[i] <= '0;
      end else if (hitSel) begin
        if (wrFld == FLD_CTRL) ctrlReg[i] <= cfgWrData[CTRL_W-1:0];
        if (wrFld == FLD_ADDR) addrCfg[i] <= cfgWrData;
      end
    end

    assign rwOk = !ctrlReg[i][BIT_RW_CARE] ||
                  (ctrlReg[i][BIT_RW_SEL] == busRead);

    if ((i % 2) == 0) begin : g_data
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dataCfg[i] <= '0;
          maskCfg[i] <= '0;
        end else if (hitSel) begin
          if (wrFld == FLD_DATA) dataCfg[i] <= cfgWrData[DATA_W-1:0];
          if (wrFld == FLD_MASK) maskCfg[i] <= cfgWrData[DATA_W-1:0];
        end
      end
      assign sizeOk = 1'b1;
    end else begin : g_size
      assign dataCfg[i] = '0;
      assign maskCfg[i] = '0;
      assign sizeOk = !ctrlReg[i][BIT_SZ_CARE] ||
                      (ctrlReg[i][BIT_SZ_SEL] == busWord);
    end

    assign strobe.qual[i] = busValid && ctrlReg[i][BIT_EN] && rwOk && sizeOk;
  end

  assign modeA = rangeMode_e'(ctrlReg[0][BIT_MODE_LO +: 2]);
  assign strobe.rangeOn     = (modeA == MODE_INSIDE) || (modeA == MODE_OUTSIDE);
  assign strobe.rangeInside = (modeA == MODE_INSIDE);

  AST_QUAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.qual != '0) |-> busValid);  // R10
endmodule

// File: rtl/bus_watch_dp.sv
module bus_watch_dp
  import bus_watch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  cmpStrobe_t                      strobe,
  input  logic                            busValid,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busData,
  input  logic [NUM_CMP-1:0][ADDR_W-1:0]  addrCfg,
  input  logic [NUM_CMP-1:0][DATA_W-1:0]  dataCfg,
  input  logic [NUM_CMP-1:0][DATA_W-1:0]  maskCfg,
  output logic [NUM_CMP-1:0]              match
);
  logic [NUM_CMP-1:0] singleHit;
  logic [NUM_CMP-1:0] nextMatch;
  logic               aboveMin;
  logic               belowMax;
  logic               inWindow;
  logic               rangeHit;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic addrEq;
    logic dataEq;
    assign addrEq = (busAddr == addrCfg[i]);
    if ((i % 2) == 0) begin : g_data
      assign dataEq = (((busData ^ dataCfg[i]) & maskCfg[i]) == '0);
    end else begin : g_addr_only
      assign dataEq = 1'b1;
    end
    assign singleHit[i] = strobe.qual[i] && addrEq && dataEq;
  end

  assign aboveMin = (busAddr >= addrCfg[0]);
  assign belowMax = (busAddr <= addrCfg[1]);
  assign inWindow = aboveMin && belowMax;
  assign rangeHit = strobe.qual[0] && (strobe.rangeInside ? inWindow : !inWindow);

  always_comb begin
    nextMatch = singleHit;
    if (strobe.rangeOn) begin
      nextMatch[0] = rangeHit;
      nextMatch[1] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) match <= '0;
    else       match <= nextMatch;
  end

  AST_IDLE_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busValid) |-> (match == '0));  // R10

  AST_RANGE_B_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.rangeOn) |-> !match[1]);  // R9

  AST_INSIDE_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    (match[0] && $past(strobe.rangeOn && strobe.rangeInside)) |->
      (($past(busAddr) >= $past(addrCfg[0])) && ($past(busAddr) <= $past(addrCfg[1]))));  // R7

  AST_OUTSIDE_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    (match[0] && $past(strobe.rangeOn && !strobe.rangeInside)) |->
      (($past(busAddr) < $past(addrCfg[0])) || ($past(busAddr) > $past(addrCfg[1]))));  // R8

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_chk
    AST_MATCH_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rstN)
      match[k] |-> $past(strobe.qual[k]));  // R6
  end
endmodule

// File: rtl/bus_watch_bank.sv
module bus_watch_bank
  import bus_watch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [3:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRead,
  input  logic              busWord,
  output logic [3:0]        match
);
  cmpStrobe_t                     strobe;
  logic [NUM_CMP-1:0][ADDR_W-1:0] addrCfg;
  logic [NUM_CMP-1:0][DATA_W-1:0] dataCfg;
  logic [NUM_CMP-1:0][DATA_W-1:0] maskCfg;

  bus_watch_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .busValid(busValid), .busRead(busRead),
    .busWord(busWord), .strobe(strobe), .addrCfg(addrCfg),
    .dataCfg(dataCfg), .maskCfg(maskCfg)
  );

  bus_watch_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busValid(busValid),
    .busAddr(busAddr), .busData(busData), .addrCfg(addrCfg),
    .dataCfg(dataCfg), .maskCfg(maskCfg), .match(match)
  );
endmodule

// File: tb/bus_watch_bank_tb_top.sv
module bus_watch_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic        busValid = 1'b0;
  logic [15:0] busAddr = '0;
  logic [15:0] busData = '0;
  logic        busRead = 1'b0;
  logic        busWord = 1'b0;
  logic [3:0]  match;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [3:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  bus_watch_bank dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .busValid(busValid), .busAddr(busAddr),
    .busData(busData), .busRead(busRead), .busWord(busWord), .match(match)
  );

  // monitor: samples 5 ns after each rising edge, when the registered result is stable
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      logic [3:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (match !== e) begin
        fails++;
        $display("FAIL %s: match=%b expected=%b", t, match, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected<=20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic busCyc(input logic v, input logic [15:0] a, input logic [15:0] d,
                        input logic rd, input logic wd, input logic [3:0] e, input string t);
    @(negedge clk);
    cfgWrEn = 1'b0;
    busValid = v; busAddr = a; busData = d; busRead = rd; busWord = wd;
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  task automatic cfgWr(input logic [1:0] cmp, input logic [1:0] fld, input logic [15:0] val);
    @(negedge clk);
    busValid = 1'b0;
    cfgWrEn = 1'b1; cfgAddr = {cmp, fld}; cfgWrData = val;
    expQ.push_back(4'b0000);
    tagQ.push_back("R10 idle during write");
  endtask

  task automatic cfgWrWithBus(input logic [1:0] cmp, input logic [1:0] fld, input logic [15:0] val,
                              input logic [15:0] a, input logic [15:0] d, input logic rd,
                              input logic wd, input logic [3:0] e, input string t);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = {cmp, fld}; cfgWrData = val;
    busValid = 1'b1; busAddr = a; busData = d; busRead = rd; busWord = wd;
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state, all disabled: a cycle at address zero matches nothing
    busCyc(1'b1, 16'h0000, 16'h0000, 1'b1, 1'b1, 4'b0000, "R11 reset disabled");

    // A: addr 1234, data AB under mask 00FF, read only
    cfgWr(2'd0, 2'd1, 16'h1234);
    cfgWr(2'd0, 2'd2, 16'h00AB);
    cfgWr(2'd0, 2'd3, 16'h00FF);
    cfgWr(2'd0, 2'd0, 16'h0007);
    // B: addr 1234, word only
    cfgWr(2'd1, 2'd1, 16'h1234);
    cfgWr(2'd1, 2'd0, 16'h0019);
    // C: addr 2000, data BEEF full mask, size bits set (no effect on C)
    cfgWr(2'd2, 2'd1, 16'h2000);
    cfgWr(2'd2, 2'd2, 16'hBEEF);
    cfgWr(2'd2, 2'd3, 16'hFFFF);
    cfgWr(2'd2, 2'd0, 16'h0019);
    // D: addr 2000, writes only
    cfgWr(2'd3, 2'd1, 16'h2000);
    cfgWr(2'd3, 2'd0, 16'h0005);

    busCyc(1'b1, 16'h1234, 16'h55AB, 1'b1, 1'b1, 4'b0011, "R1 R2 masked data A with B");
    busCyc(1'b1, 16'h1234, 16'h55AC, 1'b1, 1'b1, 4'b0010, "R2 unmasked data mismatch");
    busCyc(1'b1, 16'h1234, 16'h55AB, 1'b1, 1'b0, 4'b0001, "R5 B byte rejected");
    busCyc(1'b1, 16'h1234, 16'hFFFF, 1'b1, 1'b1, 4'b0010, "R3 B ignores data");
    busCyc(1'b1, 16'h1234, 16'h00AB, 1'b0, 1'b1, 4'b0010, "R4 A rejects write");
    busCyc(1'b1, 16'h1235, 16'h00AB, 1'b1, 1'b1, 4'b0000, "R1 address mismatch");
    busCyc(1'b1, 16'h2000, 16'hBEEF, 1'b1, 1'b0, 4'b0100, "R5 C size bits no effect");
    busCyc(1'b1, 16'h2000, 16'h0000, 1'b0, 1'b1, 4'b1000, "R4 D write only");
    busCyc(1'b1, 16'h2000, 16'hBEEF, 1'b0, 1'b0, 4'b1100, "R1 C and D together");
    busCyc(1'b1, 16'h2000, 16'h0000, 1'b1, 1'b1, 4'b0000, "R4 D rejects read");
    busCyc(1'b0, 16'h1234, 16'h00AB, 1'b1, 1'b1, 4'b0000, "R10 valid low");

    // R12: same-cycle write moves A away; old address still judges this cycle
    cfgWrWithBus(2'd0, 2'd1, 16'h3000, 16'h1234, 16'h55AB, 1'b1, 1'b1, 4'b0011, "R12 old config same cycle");
    busCyc(1'b1, 16'h1234, 16'h55AB, 1'b1, 1'b1, 4'b0010, "R12 new config next cycle");

    // R6: disable D
    cfgWr(2'd3, 2'd0, 16'h0004);
    busCyc(1'b1, 16'h2000, 16'h0000, 1'b0, 1'b1, 4'b0000, "R6 D disabled");

    // Inside window 1000..1FFF
    cfgWr(2'd0, 2'd1, 16'h1000);
    cfgWr(2'd1, 2'd1, 16'h1FFF);
    cfgWr(2'd0, 2'd0, 16'h0021);
    busCyc(1'b1, 16'h1000, 16'h0000, 1'b0, 1'b0, 4'b0001, "R7 inside at min");
    busCyc(1'b1, 16'h1FFF, 16'h0000, 1'b1, 1'b1, 4'b0001, "R7 R9 inside at max, B quiet");
    busCyc(1'b1, 16'h0FFF, 16'h0000, 1'b1, 1'b1, 4'b0000, "R7 below window");
    busCyc(1'b1, 16'h2000, 16'h0000, 1'b1, 1'b1, 4'b0000, "R7 above window");

    // Outside, reads only
    cfgWr(2'd0, 2'd0, 16'h0047);
    busCyc(1'b1, 16'h0FFF, 16'h0000, 1'b1, 1'b1, 4'b0001, "R8 outside below");
    busCyc(1'b1, 16'h2000, 16'h0000, 1'b1, 1'b1, 4'b0001, "R8 outside above");
    busCyc(1'b1, 16'h1000, 16'h0000, 1'b1, 1'b1, 4'b0000, "R8 inside edge rejected");
    busCyc(1'b1, 16'h1FFF, 16'h0000, 1'b1, 1'b1, 4'b0000, "R8 R9 max edge rejected, B quiet");
    busCyc(1'b1, 16'h0FFF, 16'h0000, 1'b0, 1'b1, 4'b0000, "R4 range honours direction");

    // R9: spare mode 11 acts as single compare; B matches alone again
    cfgWr(2'd0, 2'd0, 16'h0060);
    busCyc(1'b1, 16'h1FFF, 16'h0000, 1'b1, 1'b1, 4'b0010, "R9 spare mode single compare");

    busCyc(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'b0000, "R10 drain");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule